// File: doc/BRIEF.md
# Boot and Reset Mode Controller

This block sits between a few board controls and a microcontroller. It drives the target's active-low reset line and its mode-select pins, and it reports the current mode on a status line that feeds the host's serial RTS input. Its inputs are a reset push-button, a boot push-button, an active-low serial CTS request, an NMI push-button, a power-up reset and a slow timer tick.

After power-up the target is held in reset for a timed period and then released in user mode. A boot-button press or a CTS request toggles the mode. The target is held in reset again while the new mode is presented on the mode pins, and it latches that mode when reset is released. The reset period restarts for as long as any control input stays active. Requests that arrive while a reset is in progress are ignored.

The mode pins are driven only in boot mode. In user mode their output enable is off, so the board's pull resistors select the mode. Each debounced NMI press gives exactly one NMI pulse, and only while the target is running.

Top module: `boot_mode_ctrl`

## Requirements
- R1: While `por_n` is low the block is in user-reset: `tgt_rst_n`=0, `mode_oe`=0, `mode_val`=3'b000, `rts`=0, `nmi_n`=1.
- R2: In a reset state `tgt_rst_n` stays 0 until HOLD_TICKS `tick` pulses have been counted with no control input active. It then goes to 1 and the mode is unchanged.
- R3: While the reset button, the boot button or the CTS request (`cts_n`=0) stays active, the hold count restarts, so reset is not released.
- R4: A new debounced activation of the boot button or of the CTS request toggles the mode. From user-run the block enters boot-reset, and from boot-run it enters user-reset. One activation gives exactly one toggle, however long it is held.
- R5: A reset-button press in a run state re-enters the reset state of the same mode.
- R6: A boot or CTS activation that begins while a reset state is active causes no mode change.
- R7: In the two boot states `mode_oe`=1 and `mode_val`=3'b011. In the two user states `mode_oe`=0 and `mode_val`=3'b000.
- R8: `rts` is 1 in the boot states and 0 in the user states.
- R9: Each debounced NMI press drives `nmi_n` low for exactly one `clk` cycle, and only when the press is detected while `tgt_rst_n`=1.
- R10: An input level that lasts fewer than DEB_CNT `clk` cycles after synchronization has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| tick | input | 1 | One-cycle pulse from the slow timer that paces the reset hold |
| rst_btn | input | 1 | Reset push-button, active high |
| boot_btn | input | 1 | Boot push-button, active high |
| cts_n | input | 1 | Serial mode-change request, active low |
| nmi_btn | input | 1 | NMI push-button, active high |
| tgt_rst_n | output | 1 | Reset to the target, active low |
| mode_oe | output | 1 | Output enable for the mode-pin tri-state drivers |
| mode_val | output | 3 | Value for the mode pins while enabled |
| rts | output | 1 | Mode status: 1 for boot, 0 for user |
| nmi_n | output | 1 | NMI pulse to the target, active low |

## Verification
The bench builds the block with DEB_CNT=4 and HOLD_TICKS=8, and it pulses `tick` once every four clocks. This shortens the reset hold to about 32 cycles, so a whole toggle sequence from user mode to boot mode and back, with held buttons and requests made during reset, fits in a few hundred cycles. The short debounce count also makes it cheap to test glitches of 2 cycles against valid presses of 10 cycles or more.

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl #(
  parameter int DEB_CNT    = 50000,
  parameter int HOLD_TICKS = 550,
  parameter logic [2:0] BOOT_MODE = 3'b011
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       rst_btn,
  input  logic       boot_btn,
  input  logic       cts_n,
  input  logic       nmi_btn,
  output logic       tgt_rst_n,
  output logic       mode_oe,
  output logic [2:0] mode_val,
  output logic       rts,
  output logic       nmi_n
);
  localparam int DW = $clog2(DEB_CNT + 1);
  localparam int TW = $clog2(HOLD_TICKS + 1);
  localparam logic [DW-1:0] DEB_LAST  = DW'(DEB_CNT - 1);
  localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_TICKS - 1);

  typedef enum logic [1:0] {
    USR_RST  = 2'b00,
    USR_RUN  = 2'b01,
    BOOT_RST = 2'b10,
    BOOT_RUN = 2'b11
  } st_t;

  st_t st;
  logic [TW-1:0] tcnt;
  logic [3:0] raw, s1, s2, deb, deb_q, rise;
  logic [DW-1:0] dcnt [4];
  logic ctl_any, toggle, nmi_p;

  assign raw = {nmi_btn, ~cts_n, boot_btn, rst_btn};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1 <= '0;
      s2 <= '0;
      deb <= '0;
      deb_q <= '0;
      for (int i = 0; i < 4; i++) dcnt[i] <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      deb_q <= deb;
      for (int i = 0; i < 4; i++) begin
        if (s2[i] != deb[i]) begin
          if (dcnt[i] == DEB_LAST) begin
            deb[i] <= s2[i];
            dcnt[i] <= '0;
          end else begin
            dcnt[i] <= dcnt[i] + 1'b1;
          end
        end else begin
          dcnt[i] <= '0;
        end
      end
    end
  end

  assign rise    = deb & ~deb_q;
  assign ctl_any = |deb[2:0];
  assign toggle  = rise[1] | rise[2];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= USR_RST;
      tcnt <= '0;
    end else begin
      case (st)
        USR_RST, BOOT_RST: begin
          if (ctl_any) tcnt <= '0;
          else if (tick) begin
            if (tcnt == HOLD_LAST) begin
              tcnt <= '0;
              st <= (st == USR_RST) ? USR_RUN : BOOT_RUN;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        USR_RUN: begin
          tcnt <= '0;
          if (toggle) st <= BOOT_RST;
          else if (deb[0]) st <= USR_RST;
        end
        default: begin
          tcnt <= '0;
          if (toggle) st <= USR_RST;
          else if (deb[0]) st <= BOOT_RST;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) nmi_p <= 1'b0;
    else        nmi_p <= rise[3] & st[0];
  end

  assign tgt_rst_n = st[0];
  assign mode_oe   = st[1];
  assign mode_val  = st[1] ? BOOT_MODE : 3'b000;
  assign rts       = st[1];
  assign nmi_n     = ~nmi_p;
endmodule

module boot_mode_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       tgt_rst_n,
  input logic       mode_oe,
  input logic [2:0] mode_val,
  input logic       rts,
  input logic       nmi_n,
  input logic       ctl_any
);
  assert_user_pins_R7: assert property (@(posedge clk) disable iff (!por_n)
    !mode_oe |-> mode_val == 3'b000);
  assert_status_R8: assert property (@(posedge clk) disable iff (!por_n)
    rts == mode_oe);
  assert_mode_in_reset_R4: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(rts) |-> !tgt_rst_n);
  assert_release_quiet_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(tgt_rst_n) |-> $past(!ctl_any));
  assert_nmi_single_R9: assert property (@(posedge clk) disable iff (!por_n)
    !nmi_n |=> nmi_n);
  assert_nmi_running_R9: assert property (@(posedge clk) disable iff (!por_n)
    !nmi_n |-> $past(tgt_rst_n));
endmodule

bind boot_mode_ctrl boot_mode_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .tgt_rst_n(tgt_rst_n), .mode_oe(mode_oe),
  .mode_val(mode_val), .rts(rts), .nmi_n(nmi_n), .ctl_any(ctl_any)
);

// File: tb/sim_boot_mode_ctrl.sv
`timescale 1ns/1ps
module sim_boot_mode_ctrl;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic tick = 1'b0;
  logic rst_btn = 1'b0, boot_btn = 1'b0, cts_n = 1'b1, nmi_btn = 1'b0;
  logic tgt_rst_n, mode_oe, rts, nmi_n;
  logic [2:0] mode_val;
  int checks = 0;
  int errors = 0;
  int nmi_edges = 0;
  int nmi_low = 0;
  logic nmi_prev = 1'b1;

  always #2 clk = ~clk;

  boot_mode_ctrl #(.DEB_CNT(4), .HOLD_TICKS(8)) u0 (
    .clk(clk), .por_n(por_n), .tick(tick), .rst_btn(rst_btn),
    .boot_btn(boot_btn), .cts_n(cts_n), .nmi_btn(nmi_btn),
    .tgt_rst_n(tgt_rst_n), .mode_oe(mode_oe), .mode_val(mode_val),
    .rts(rts), .nmi_n(nmi_n)
  );

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      tick = (k % 4 == 3);
      k++;
    end
  end

  always @(negedge clk) begin
    if (!nmi_n) nmi_low++;
    if (nmi_prev && !nmi_n) nmi_edges++;
    nmi_prev = nmi_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic er, input logic et,
                         input logic eo, input logic [2:0] em);
    chk({req, " tgt_rst_n"}, int'(tgt_rst_n), int'(er));
    chk({req, " rts"}, int'(rts), int'(et));
    chk({req, " mode_oe"}, int'(mode_oe), int'(eo));
    chk({req, " mode_val"}, int'(mode_val), int'(em));
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {wait, rst_btn, boot_btn, cts_n, nmi_btn, exp rst_n, exp rts, exp oe, exp mode}
  localparam logic [17:0] VEC [13] = '{
    {8'd60,  4'b0010, 3'b100, 3'b000},
    {8'd15,  4'b0100, 3'b011, 3'b011},
    {8'd60,  4'b0010, 3'b111, 3'b011},
    {8'd15,  4'b0100, 3'b000, 3'b000},
    {8'd60,  4'b0010, 3'b100, 3'b000},
    {8'd15,  4'b0000, 3'b011, 3'b011},
    {8'd60,  4'b0010, 3'b111, 3'b011},
    {8'd15,  4'b1010, 3'b011, 3'b011},
    {8'd100, 4'b1010, 3'b011, 3'b011},
    {8'd60,  4'b0010, 3'b111, 3'b011},
    {8'd15,  4'b0000, 3'b000, 3'b000},
    {8'd15,  4'b0110, 3'b000, 3'b000},
    {8'd60,  4'b0010, 3'b100, 3'b000}
  };

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int e0;
    wait_n(5);
    chk_out("R1 power-up", 1'b0, 1'b0, 1'b0, 3'b000);
    chk("R1 nmi idle", int'(nmi_n), 1);
    por_n = 1'b1;
    wait_n(20);
    chk("R2 hold after power-up", int'(tgt_rst_n), 0);
    wait_n(30);
    chk("R2 release after power-up", int'(tgt_rst_n), 1);

    // R3 R4 R5 R6 R7 R8 walked through the vector table
    for (int i = 0; i < 13; i++) begin
      logic [17:0] v;
      v = VEC[i];
      {rst_btn, boot_btn, cts_n, nmi_btn} = v[9:6];
      wait_n(int'(v[17:10]));
      chk_out($sformatf("vector %0d R3/R4/R5/R6/R7/R8", i), v[5], v[4], v[3], v[2:0]);
    end

    // R4: long boot hold gives one toggle only
    boot_btn = 1'b1; wait_n(200);
    chk_out("R4 long hold in reset", 1'b0, 1'b1, 1'b1, 3'b011);
    boot_btn = 1'b0; wait_n(60);
    chk_out("R4 long hold single toggle", 1'b1, 1'b1, 1'b1, 3'b011);
    boot_btn = 1'b1; wait_n(15); boot_btn = 1'b0; wait_n(60);
    chk_out("R4 back to user", 1'b1, 1'b0, 1'b0, 3'b000);

    // R10: glitch on boot button is ignored
    boot_btn = 1'b1; wait_n(2); boot_btn = 1'b0; wait_n(30);
    chk_out("R10 boot glitch", 1'b1, 1'b0, 1'b0, 3'b000);

    // R9: long NMI press gives one single-cycle pulse
    e0 = nmi_edges; nmi_low = 0;
    nmi_btn = 1'b1; wait_n(200); nmi_btn = 1'b0; wait_n(30);
    chk("R9 long press pulses", nmi_edges - e0, 1);
    chk("R9 pulse width", nmi_low, 1);

    // R9: a valid short press
    e0 = nmi_edges;
    nmi_btn = 1'b1; wait_n(10); nmi_btn = 1'b0; wait_n(30);
    chk("R9 short press pulses", nmi_edges - e0, 1);

    // R10: NMI glitch
    e0 = nmi_edges;
    nmi_btn = 1'b1; wait_n(2); nmi_btn = 1'b0; wait_n(30);
    chk("R10 nmi glitch pulses", nmi_edges - e0, 0);

    // R9: no NMI while in reset
    e0 = nmi_edges;
    rst_btn = 1'b1; wait_n(15);
    nmi_btn = 1'b1; wait_n(20); nmi_btn = 1'b0; wait_n(15);
    rst_btn = 1'b0; wait_n(60);
    chk("R9 nmi in reset pulses", nmi_edges - e0, 0);
    chk_out("R5 user reset return", 1'b1, 1'b0, 1'b0, 3'b000);

    finish_run();
  end
endmodule